// File: doc/BRIEF.md
# Cross-coupled wait-for-event unit

This unit models how two processor cores put themselves to sleep and wake each other without interrupts. Each core may raise a wait request, a send request and an interrupt-wake input. Each core has a pending-event flag. A wait request either puts the core to sleep or, when an event is already pending, consumes the flag and returns at once. A send request from a running core becomes a one-cycle event pulse on that core's event output. That pulse is routed to the other core's event input.

An incoming event does one of two things. On a running core it sets the pending flag. On a sleeping core it ends sleep without leaving the flag set. A core that sends an event also sets its own pending flag. The separate interrupt-wake input also ends sleep. All control pins are plain single-cycle strobes or levels, with no handshake. Each output bit belongs to the core with the same index (bit 0 is core 0).

Top module: `wfe_pair_sync`

## Requirements
- R1: After reset both cores are awake, `sleeping_o`, `evt_tx_o` and `wake_pulse_o` are all 0, and both pending flags are clear, so a first wait request puts a core to sleep.
- R2: A send request sampled on an edge while its core is awake drives that core's `evt_tx_o` bit high for exactly the cycle after that edge.
- R3: Core 0's event output feeds core 1's event input, and core 1's event output feeds core 0's event input. A core never receives its own event.
- R4: A wait request on an awake core with no pending flag, no incoming event, no own send request and no interrupt-wake sets that core's `sleeping_o` bit after the sampling edge.
- R5: A wait request on an awake core whose flag is pending keeps the core awake and clears the flag, so a second wait request then puts it to sleep.
- R6: An incoming event on an awake core without a wait request sets its pending flag.
- R7: An incoming event on a sleeping core clears `sleeping_o` at the next edge. It raises `wake_pulse_o` for exactly one cycle and leaves the pending flag clear.
- R8: A send request from an awake core also sets that core's own pending flag.
- R9: An interrupt-wake on a sleeping core clears `sleeping_o` at the next edge and raises `wake_pulse_o` for one cycle. The pending flag stays clear.
- R10: A wait request that meets an incoming event in the same cycle does not put the core to sleep and leaves the pending flag clear.
- R11: While a core sleeps, its wait and send requests have no effect: the core stays asleep, its `evt_tx_o` bit stays 0, and the other core receives no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_req_i | input | 2 | Per-core wait-for-event request strobe |
| send_req_i | input | 2 | Per-core send-event request strobe |
| irq_wake_i | input | 2 | Per-core interrupt-wake input |
| evt_tx_o | output | 2 | Per-core one-cycle event output pulse |
| sleeping_o | output | 2 | Per-core sleep flag |
| wake_pulse_o | output | 2 | Per-core one-cycle wake indication |

## Verification
Every input is sampled on one rising edge. `sleeping_o` and `wake_pulse_o` change right after the edge that samples a wait request, an interrupt-wake or an incoming event. A send request shows on `evt_tx_o` one edge after it is sampled, and it reaches the other core's state on the edge after that.

The bench drives inputs on the falling edge and reads results on the next falling edge. Event delivery is therefore checked two falling edges after the send request, and wake pulses are checked for one cycle high and then low. The pending flag is hidden, so it is read out through the ports: a follow-up wait request either sleeps or does not.

// File: rtl/wfe_pkg.sv
package wfe_pkg;

  localparam int unsigned PAIR_CORES = 2;

  typedef enum logic {
    CORE_RUN   = 1'b0,
    CORE_SLEEP = 1'b1
  } core_state_e;

  // per-core stimulus bundle seen on one clock edge
  typedef struct packed {
    logic wait_req;
    logic send_req;
    logic evt_in;
    logic irq_wake;
  } core_stim_t;

endpackage

// File: rtl/wfe_evt_tx.sv
module wfe_evt_tx #(
  parameter int unsigned N_CORES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CORES-1:0] send_req,
  input  logic [N_CORES-1:0] asleep,
  output logic [N_CORES-1:0] evt_tx
);

  for (genvar gi = 0; gi < N_CORES; gi++) begin : g_tx
    always_ff @(posedge clk) begin
      if (!rst_n) evt_tx[gi] <= 1'b0;
      else        evt_tx[gi] <= send_req[gi] & ~asleep[gi];
    end

    // R2: an accepted send request shows as a pulse one edge later
    p_tx_after_send_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (send_req[gi] && !asleep[gi]) |=> evt_tx[gi]);

    // R11: a sleeping core emits nothing
    p_no_tx_asleep_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep[gi] || !send_req[gi]) |=> !evt_tx[gi]);
  end

endmodule

// File: rtl/wfe_evt_route.sv
module wfe_evt_route #(
  parameter int unsigned N_CORES = 2
) (
  input  logic [N_CORES-1:0] evt_tx,
  output logic [N_CORES-1:0] evt_rx
);

  for (genvar gi = 0; gi < N_CORES; gi++) begin : g_route
    localparam logic [N_CORES-1:0] SELF_MASK = N_CORES'(1) << gi;
    // every other core's event reaches this core, its own never does
    assign evt_rx[gi] = |(evt_tx & ~SELF_MASK);
  end

endmodule

// File: rtl/wfe_core_ctrl.sv
module wfe_core_ctrl
  import wfe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  core_stim_t stim,
  output logic       asleep,
  output logic       wake_pulse
);

  core_state_e state_q, state_d;
  logic        latch_q, latch_d;
  logic        wake_d;
  logic        pending;

  assign pending = latch_q | stim.evt_in | stim.send_req;

  always_comb begin
    state_d = state_q;
    latch_d = latch_q;
    wake_d  = 1'b0;
    unique case (state_q)
      CORE_RUN: begin
        if (stim.wait_req) begin
          latch_d = 1'b0;
          if (!pending && !stim.irq_wake) state_d = CORE_SLEEP;
        end else begin
          latch_d = pending;
        end
      end
      CORE_SLEEP: begin
        if (stim.evt_in || stim.irq_wake) begin
          state_d = CORE_RUN;
          wake_d  = 1'b1;
          latch_d = 1'b0;
        end
      end
      default: state_d = CORE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= CORE_RUN;
      latch_q    <= 1'b0;
      wake_pulse <= 1'b0;
    end else begin
      state_q    <= state_d;
      latch_q    <= latch_d;
      wake_pulse <= wake_d;
    end
  end

  assign asleep = (state_q == CORE_SLEEP);

  // R4: a clean wait request leads to sleep
  p_clean_wait_sleeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && stim.wait_req && !latch_q && !stim.evt_in && !stim.send_req && !stim.irq_wake)
    |=> asleep);

  // R5 / R10: a pending or arriving event consumes the wait
  p_pending_wait_returns_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && stim.wait_req && (latch_q || stim.evt_in || stim.send_req))
    |=> (!asleep && !latch_q));

  // R7: event wake-up leaves the flag clear and pulses once
  p_event_wakes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && stim.evt_in) |=> (!asleep && wake_pulse && !latch_q));

  // R9: interrupt wake-up
  p_irq_wakes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && stim.irq_wake) |=> (!asleep && wake_pulse));

  // R11: nothing else disturbs a sleeping core
  p_sleep_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !stim.evt_in && !stim.irq_wake) |=> (asleep && !wake_pulse));

  // R7: the wake pulse never lasts beyond one cycle
  p_wake_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

endmodule

// File: rtl/wfe_pair_sync.sv
module wfe_pair_sync
  import wfe_pkg::*;
#(
  parameter int unsigned N_CORES = PAIR_CORES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CORES-1:0] wait_req_i,
  input  logic [N_CORES-1:0] send_req_i,
  input  logic [N_CORES-1:0] irq_wake_i,
  output logic [N_CORES-1:0] evt_tx_o,
  output logic [N_CORES-1:0] sleeping_o,
  output logic [N_CORES-1:0] wake_pulse_o
);

  logic [N_CORES-1:0] evt_rx;

  wfe_evt_tx #(.N_CORES(N_CORES)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .send_req (send_req_i),
    .asleep   (sleeping_o),
    .evt_tx   (evt_tx_o)
  );

  wfe_evt_route #(.N_CORES(N_CORES)) u_route (
    .evt_tx (evt_tx_o),
    .evt_rx (evt_rx)
  );

  for (genvar gi = 0; gi < N_CORES; gi++) begin : g_core
    core_stim_t stim;
    assign stim.wait_req = wait_req_i[gi];
    assign stim.send_req = send_req_i[gi];
    assign stim.evt_in   = evt_rx[gi];
    assign stim.irq_wake = irq_wake_i[gi];

    wfe_core_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .stim       (stim),
      .asleep     (sleeping_o[gi]),
      .wake_pulse (wake_pulse_o[gi])
    );
  end

  if (N_CORES == 2) begin : g_pair_chk
    // R3: each core's event pulse wakes the opposite sleeping core
    p_cross_0to1_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_tx_o[0] && sleeping_o[1]) |=> !sleeping_o[1]);
    p_cross_1to0_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_tx_o[1] && sleeping_o[0]) |=> !sleeping_o[0]);
  end

endmodule

// File: tb/sim_wfe_pair_sync.sv
`timescale 1ns/1ps
module sim_wfe_pair_sync;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] wait_req = '0;
  logic [1:0] send_req = '0;
  logic [1:0] irq_wake = '0;
  logic [1:0] evt_tx, sleeping, wake_pulse;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  wfe_pair_sync u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .wait_req_i   (wait_req),
    .send_req_i   (send_req),
    .irq_wake_i   (irq_wake),
    .evt_tx_o     (evt_tx),
    .sleeping_o   (sleeping),
    .wake_pulse_o (wake_pulse)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input logic [1:0] w, input logic [1:0] s, input logic [1:0] i);
    wait_req = w; send_req = s; irq_wake = i;
    tick();
    wait_req = '0; send_req = '0; irq_wake = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_req = '0; send_req = '0; irq_wake = '0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic t_reset_r1();
    do_reset();
    check("R1 sleeping", sleeping, 2'b00);
    check("R1 evt_tx", evt_tx, 2'b00);
    check("R1 wake", wake_pulse, 2'b00);
    pulse(2'b11, 2'b00, 2'b00);
    check("R1 flags clear -> both sleep", sleeping, 2'b11);
  endtask

  task automatic t_clean_wait_r4();
    do_reset();
    pulse(2'b01, 2'b00, 2'b00);
    check("R4 core0 sleeps", sleeping, 2'b01);
    tick();
    check("R4 stays asleep", sleeping, 2'b01);
  endtask

  task automatic t_send_pulse_r2_r3_r6();
    do_reset();
    pulse(2'b00, 2'b01, 2'b00);
    check("R2 tx pulse core0", evt_tx, 2'b01);
    tick();
    check("R2 tx one cycle", evt_tx, 2'b00);
    pulse(2'b10, 2'b00, 2'b00);
    check("R3 R6 core1 flag set, wait returns", sleeping, 2'b00);
    pulse(2'b00, 2'b10, 2'b00);
    check("R2 tx pulse core1", evt_tx, 2'b10);
    tick();
    pulse(2'b01, 2'b00, 2'b00);
    check("R3 R6 core0 flag set, wait returns", sleeping, 2'b00);
  endtask

  task automatic t_own_flag_r5_r8();
    do_reset();
    pulse(2'b00, 2'b01, 2'b00);
    tick();
    pulse(2'b01, 2'b00, 2'b00);
    check("R8 sender own flag set", sleeping, 2'b00);
    pulse(2'b01, 2'b00, 2'b00);
    check("R5 flag consumed, second wait sleeps", sleeping, 2'b01);
  endtask

  task automatic t_event_wake_r7();
    do_reset();
    pulse(2'b10, 2'b00, 2'b00);
    check("R7 core1 asleep", sleeping, 2'b10);
    pulse(2'b00, 2'b01, 2'b00);
    check("R7 not yet woken", sleeping, 2'b10);
    check("R7 no early wake", wake_pulse, 2'b00);
    tick();
    check("R7 core1 awake", sleeping, 2'b00);
    check("R7 wake pulse", wake_pulse, 2'b10);
    tick();
    check("R7 wake pulse ends", wake_pulse, 2'b00);
    pulse(2'b10, 2'b00, 2'b00);
    check("R7 flag left clear", sleeping, 2'b10);
  endtask

  task automatic t_irq_wake_r9();
    do_reset();
    pulse(2'b01, 2'b00, 2'b00);
    pulse(2'b00, 2'b00, 2'b01);
    check("R9 irq wakes core0", sleeping, 2'b00);
    check("R9 wake pulse", wake_pulse, 2'b01);
    tick();
    check("R9 wake pulse ends", wake_pulse, 2'b00);
    pulse(2'b01, 2'b00, 2'b00);
    check("R9 flag stays clear", sleeping, 2'b01);
  endtask

  task automatic t_same_cycle_r10();
    do_reset();
    pulse(2'b00, 2'b01, 2'b00);
    pulse(2'b10, 2'b00, 2'b00);
    check("R10 wait meets event, no sleep", sleeping, 2'b00);
    pulse(2'b10, 2'b00, 2'b00);
    check("R10 flag ends clear", sleeping, 2'b10);
  endtask

  task automatic t_sleep_ignore_r11();
    do_reset();
    pulse(2'b01, 2'b00, 2'b00);
    pulse(2'b00, 2'b01, 2'b00);
    check("R11 no tx while asleep", evt_tx, 2'b00);
    check("R11 still asleep after send", sleeping, 2'b01);
    pulse(2'b01, 2'b00, 2'b00);
    check("R11 still asleep after wait", sleeping, 2'b01);
    pulse(2'b10, 2'b00, 2'b00);
    check("R11 no event reached core1", sleeping, 2'b11);
  endtask

  initial begin
    t_reset_r1();
    t_clean_wait_r4();
    t_send_pulse_r2_r3_r6();
    t_own_flag_r5_r8();
    t_event_wake_r7();
    t_irq_wake_r9();
    t_same_cycle_r10();
    t_sleep_ignore_r11();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule